// File: doc/BRIEF.md
# Suspend Refresh Clock-Enable Controller

This block drives the memory clock-enable lines while the system goes into and comes out of suspend. A two-bit board-layout setting picks one of three output arrangements. The first drives six per-row enables and lowers them one row at a time. The second drives only the row-0 enable and lowers it in a single step. The third drives one global enable that an external buffer fans out, and lowers it after one stagger interval. The same setting decides whether dynamic power-down may be used while the controller is idle.

When registered memory modules are fitted, or the memory is of the older EDO type, the clock-enable lines are never lowered. Registered SDRAM, and EDO memory set for CAS-before-RAS, are kept alive by a refresh request that pulses each time a programmable counter expires. EDO memory set for self-refresh gets a level self-refresh command instead. The configuration inputs are sampled only while the controller is idle. A done flag tells the power sequencer that every driven enable is low.

Top module: `sref_cke_ctrl`

## Requirements
- R1: While reset is held and after it is released, every row enable and the global enable are high, and done, refresh request and self-refresh command are low.
- R2: Layout code 00 (bit 1 = 0, bit 0 = 0), unregistered SDRAM: after suspend is sampled high, rows 0..5 go low one at a time in ascending order, and done rises together with row 5. With an interval of one clock, row k falls on the (k+2)-th rising edge after suspend is driven high.
- R3: Layout code 01: only row 0 goes low, one clock after suspend is taken, whatever the interval setting. Rows 1..5 and the global enable stay high, and done rises together with row 0.
- R4: Layout codes 10 and 11: only the global enable goes low, one interval after suspend is taken. All row outputs stay high.
- R5: The power-down permit is high only while idle with layout code 00, unregistered and not EDO. It is low in every other layout and throughout suspend.
- R6: When suspend is sampled low, done clears on that edge, and the lowered enables rise again in ascending row order at the same interval. When suspend drops on the same edge that would lower the last row, that row is not lowered and done never rises.
- R7: With the registered flag set (and EDO clear), all enables stay high, done rises one clock after suspend is taken, and a one-clock refresh request pulses once every refresh-period clocks.
- R8: EDO with the refresh-type bit at 1 (CAS-before-RAS) pulses the refresh request once every refresh-period clocks while suspend is held. With the bit at 0, the self-refresh command is high throughout suspend and no refresh request is issued. In both cases the enables stay high.
- R9: Changes to the configuration inputs while the controller is not idle have no effect until it is idle again.
- R10: The stagger interval input sets the number of clocks between successive enable changes. Values 0 and 1 both mean one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| suspend_req | input | 1 | Suspend request level |
| cfg_layout | input | 2 | Board layout code: 00 six rows, 01 row 0 only, 1x global enable |
| cfg_regdimm | input | 1 | Registered memory modules fitted |
| cfg_edo | input | 1 | Memory is EDO type |
| cfg_cbr | input | 1 | EDO suspend refresh type: 1 CAS-before-RAS, 0 self-refresh |
| cfg_stagger | input | STG_W | Clocks between enable steps (0 treated as 1) |
| cfg_ref_period | input | REF_W | Clocks between refresh requests (0 treated as 1) |
| cke_row | output | NUM_ROWS | Per-row clock enables |
| cke_glb | output | 1 | Global clock enable for an external driver |
| pd_allow | output | 1 | Dynamic power-down permitted |
| ref_req | output | 1 | One-clock refresh request pulse |
| sref_cmd | output | 1 | EDO self-refresh command level |
| done | output | 1 | All driven enables are low |

## Verification
The collision of interest is a wake request that lands on the same edge that would lower the final row. On that edge, completing the stagger and starting the exit contend for the sequencer. The bench drops suspend so that it is sampled on the sixth stagger edge with a one-clock interval. It then checks that row 5 is still high, that done never rises, and that rows 0 to 4 come back in order. A second overlap is a configuration write during suspend: the bench changes every configuration input mid-suspend and checks that the row outputs, refresh request and self-refresh command keep the behaviour of the layout latched at entry.

// File: rtl/sref_pkg.sv
package sref_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ENTER = 2'd1,
      ST_SUSP  = 2'd2,
      ST_EXIT  = 2'd3
   } sref_state_e;

   localparam logic [1:0] LAYOUT_SIX = 2'b00;
   localparam logic [1:0] LAYOUT_ONE = 2'b01;

   typedef struct packed {
      logic [1:0] layout;
      logic       regd;
      logic       edo;
      logic       cbr;
   } sref_cfg_t;

endpackage

// File: rtl/sref_cke_seq.sv
module sref_cke_seq
   import sref_pkg::*;
#(
   parameter int NUM_ROWS = 6,
   parameter int STG_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                suspend_req,
   input  logic [1:0]          layout,
   input  logic                regd,
   input  logic                edo,
   input  logic [STG_W-1:0]    stg_lim,
   output logic [NUM_ROWS-1:0] cke_q,
   output sref_state_e         state_q,
   output logic                done_q
);
   localparam int IDX_W = $clog2(NUM_ROWS + 1);
   localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(NUM_ROWS - 1);

   logic             ctl_cke;
   logic             stag;
   logic             step;
   logic [IDX_W-1:0] last_idx;
   logic [IDX_W-1:0] idx_q;
   logic [STG_W-1:0] tmr_q;

   assign ctl_cke  = !regd && !edo;
   assign stag     = (layout != LAYOUT_ONE);
   assign last_idx = (layout == LAYOUT_SIX) ? LAST_ROW : '0;
   assign step     = (tmr_q == stg_lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cke_q   <= '1;
         idx_q   <= '0;
         tmr_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               idx_q <= '0;
               tmr_q <= '0;
               if (suspend_req) begin
                  if (ctl_cke) begin
                     state_q <= ST_ENTER;
                  end else begin
                     state_q <= ST_SUSP;
                     done_q  <= 1'b1;
                  end
               end
            end
            ST_ENTER: begin
               if (!suspend_req) begin
                  state_q <= ST_EXIT;
                  idx_q   <= '0;
                  tmr_q   <= '0;
               end else if (!stag) begin
                  cke_q[0] <= 1'b0;
                  state_q  <= ST_SUSP;
                  done_q   <= 1'b1;
               end else if (step) begin
                  for (int i = 0; i < NUM_ROWS; i++)
                     if (IDX_W'(i) == idx_q) cke_q[i] <= 1'b0;
                  idx_q <= idx_q + 1'b1;
                  tmr_q <= '0;
                  if (idx_q == last_idx) begin
                     state_q <= ST_SUSP;
                     done_q  <= 1'b1;
                  end
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            ST_SUSP: begin
               if (!suspend_req) begin
                  done_q  <= 1'b0;
                  idx_q   <= '0;
                  tmr_q   <= '0;
                  state_q <= ctl_cke ? ST_EXIT : ST_IDLE;
               end
            end
            default: begin
               if (!stag) begin
                  cke_q   <= '1;
                  state_q <= ST_IDLE;
               end else if (step) begin
                  for (int i = 0; i < NUM_ROWS; i++)
                     if (IDX_W'(i) == idx_q) cke_q[i] <= 1'b1;
                  idx_q <= idx_q + 1'b1;
                  tmr_q <= '0;
                  if (idx_q == last_idx) begin
                     cke_q   <= '1;
                     state_q <= ST_IDLE;
                  end
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
         endcase
      end
   end

   // R2: in the six-row layout at most one enable moves per clock
   p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (layout == LAYOUT_SIX) |-> ($countones(cke_q ^ $past(cke_q)) <= 1));

   // R2: done in the six-row layout means every row is low
   p_done_all_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && ctl_cke && layout == LAYOUT_SIX) |-> (cke_q == '0));

   // R6: a wake sampled in suspend clears done on the next cycle
   p_wake_clears_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SUSP && !suspend_req) |=> !done_q);

endmodule

// File: rtl/sref_ref_timer.sv
module sref_ref_timer #(
   parameter int REF_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [REF_W-1:0] lim,
   output logic             pulse
);
   logic [REF_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt_q <= '0;
         pulse <= 1'b0;
      end else if (cnt_q == lim) begin
         cnt_q <= '0;
         pulse <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         pulse <= 1'b0;
      end
   end

   // R8: a refresh request follows only a cycle in which refresh was enabled
   p_ref_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> $past(en));

endmodule

// File: rtl/sref_cke_map.sv
module sref_cke_map
   import sref_pkg::*;
#(
   parameter int NUM_ROWS = 6
) (
   input  logic [1:0]          layout,
   input  logic [NUM_ROWS-1:0] cke_q,
   output logic [NUM_ROWS-1:0] cke_row,
   output logic                cke_glb
);
   for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
      if (i == 0) begin : g_first
         assign cke_row[i] = layout[1] ? 1'b1 : cke_q[i];
      end else begin : g_rest
         assign cke_row[i] = (layout == LAYOUT_SIX) ? cke_q[i] : 1'b1;
      end
   end

   assign cke_glb = layout[1] ? cke_q[0] : 1'b1;

endmodule

// File: rtl/sref_cke_ctrl.sv
module sref_cke_ctrl
   import sref_pkg::*;
#(
   parameter int NUM_ROWS = 6,
   parameter int STG_W    = 4,
   parameter int REF_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                suspend_req,
   input  logic [1:0]          cfg_layout,
   input  logic                cfg_regdimm,
   input  logic                cfg_edo,
   input  logic                cfg_cbr,
   input  logic [STG_W-1:0]    cfg_stagger,
   input  logic [REF_W-1:0]    cfg_ref_period,
   output logic [NUM_ROWS-1:0] cke_row,
   output logic                cke_glb,
   output logic                pd_allow,
   output logic                ref_req,
   output logic                sref_cmd,
   output logic                done
);
   if (NUM_ROWS < 2) begin : g_bad_rows
      $error("NUM_ROWS must be at least 2");
   end
   if (STG_W < 1 || REF_W < 1) begin : g_bad_width
      $error("STG_W and REF_W must be at least 1");
   end

   sref_cfg_t           cfg_in, cfg_q, cfg_eff;
   logic [STG_W-1:0]    stg_q, stg_eff, stg_lim;
   logic [REF_W-1:0]    per_q, per_lim;
   logic [NUM_ROWS-1:0] cke_q;
   sref_state_e         state_q;
   logic                idle;
   logic                ref_en;

   assign cfg_in  = '{layout: cfg_layout, regd: cfg_regdimm, edo: cfg_edo, cbr: cfg_cbr};
   assign idle    = (state_q == ST_IDLE);
   assign cfg_eff = idle ? cfg_in : cfg_q;
   assign stg_eff = idle ? cfg_stagger : stg_q;
   assign stg_lim = (stg_eff == '0) ? '0 : stg_eff - 1'b1;
   assign per_lim = (per_q == '0) ? '0 : per_q - 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
         stg_q <= STG_W'(1);
         per_q <= REF_W'(1);
      end else if (idle) begin
         cfg_q <= cfg_in;
         stg_q <= cfg_stagger;
         per_q <= cfg_ref_period;
      end
   end

   sref_cke_seq #(.NUM_ROWS(NUM_ROWS), .STG_W(STG_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .suspend_req (suspend_req),
      .layout      (cfg_eff.layout),
      .regd        (cfg_eff.regd),
      .edo         (cfg_eff.edo),
      .stg_lim     (stg_lim),
      .cke_q       (cke_q),
      .state_q     (state_q),
      .done_q      (done)
   );

   assign ref_en = (state_q == ST_SUSP) &&
                   ((cfg_q.edo && cfg_q.cbr) || (!cfg_q.edo && cfg_q.regd));

   sref_ref_timer #(.REF_W(REF_W)) u_ref (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ref_en),
      .lim   (per_lim),
      .pulse (ref_req)
   );

   sref_cke_map #(.NUM_ROWS(NUM_ROWS)) u_map (
      .layout  (cfg_eff.layout),
      .cke_q   (cke_q),
      .cke_row (cke_row),
      .cke_glb (cke_glb)
   );

   assign sref_cmd = (state_q == ST_SUSP) && cfg_q.edo && !cfg_q.cbr;
   assign pd_allow = idle && (cfg_q.layout == LAYOUT_SIX) && !cfg_q.regd && !cfg_q.edo;

   // R9: latched configuration holds while the controller is not idle
   p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> $stable(cfg_q));

   // R7: registered modules keep every enable high
   p_reg_cke_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.regd |-> (&cke_row && cke_glb));

   // R5: power-down is never permitted during suspend
   p_no_pd_in_susp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_req && !idle |-> !pd_allow);

endmodule

// File: tb/test_sref_cke_ctrl.sv
module test_sref_cke_ctrl;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       suspend_req;
   logic [1:0] cfg_layout;
   logic       cfg_regdimm, cfg_edo, cfg_cbr;
   logic [3:0] cfg_stagger;
   logic [7:0] cfg_ref_period;
   logic [5:0] cke_row;
   logic       cke_glb, pd_allow, ref_req, sref_cmd, done;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   sref_cke_ctrl i_sref_cke_ctrl (
      .clk(clk), .rst_n(rst_n), .suspend_req(suspend_req),
      .cfg_layout(cfg_layout), .cfg_regdimm(cfg_regdimm), .cfg_edo(cfg_edo),
      .cfg_cbr(cfg_cbr), .cfg_stagger(cfg_stagger), .cfg_ref_period(cfg_ref_period),
      .cke_row(cke_row), .cke_glb(cke_glb), .pd_allow(pd_allow),
      .ref_req(ref_req), .sref_cmd(sref_cmd), .done(done)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   typedef struct packed {
      logic [1:0] layout;
      logic       regd;
      logic       edo;
      logic       cbr;
      logic [3:0] stg;
      logic [7:0] per;
      logic [7:0] lat;
      logic [5:0] rows;
      logic       glb;
      logic       pd;
      logic [7:0] nref;
      logic       sref;
      logic [7:0] wlat;
      logic [7:0] req;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VT [NV] = '{
      '{2'b00, 1'b0, 1'b0, 1'b0, 4'd1, 8'd4,  8'd7, 6'h00, 1'b1, 1'b1, 8'd0, 1'b0,  8'd7,  8'd2}, // R2
      '{2'b00, 1'b0, 1'b0, 1'b0, 4'd3, 8'd4, 8'd19, 6'h00, 1'b1, 1'b1, 8'd0, 1'b0, 8'd19, 8'd10}, // R10
      '{2'b01, 1'b0, 1'b0, 1'b0, 4'd1, 8'd4,  8'd2, 6'h3E, 1'b1, 1'b0, 8'd0, 1'b0,  8'd2,  8'd3}, // R3
      '{2'b01, 1'b0, 1'b0, 1'b0, 4'd4, 8'd4,  8'd2, 6'h3E, 1'b1, 1'b0, 8'd0, 1'b0,  8'd2,  8'd3}, // R3
      '{2'b10, 1'b0, 1'b0, 1'b0, 4'd2, 8'd4,  8'd3, 6'h3F, 1'b0, 1'b0, 8'd0, 1'b0,  8'd3,  8'd4}, // R4
      '{2'b11, 1'b0, 1'b0, 1'b0, 4'd0, 8'd4,  8'd2, 6'h3F, 1'b0, 1'b0, 8'd0, 1'b0,  8'd2,  8'd4}, // R4
      '{2'b00, 1'b1, 1'b0, 1'b0, 4'd1, 8'd4,  8'd1, 6'h3F, 1'b1, 1'b0, 8'd4, 1'b0,  8'd1,  8'd7}, // R7
      '{2'b00, 1'b0, 1'b1, 1'b1, 4'd1, 8'd4,  8'd1, 6'h3F, 1'b1, 1'b0, 8'd4, 1'b0,  8'd1,  8'd8}, // R8
      '{2'b00, 1'b0, 1'b1, 1'b1, 4'd1, 8'd8,  8'd1, 6'h3F, 1'b1, 1'b0, 8'd2, 1'b0,  8'd1,  8'd8}, // R8
      '{2'b10, 1'b0, 1'b1, 1'b0, 4'd1, 8'd4,  8'd1, 6'h3F, 1'b1, 1'b0, 8'd0, 1'b1,  8'd1,  8'd8}  // R8
   };

   task automatic set_cfg(input logic [1:0] l, input logic r, input logic e,
                          input logic c, input logic [3:0] s, input logic [7:0] p);
      cfg_layout = l; cfg_regdimm = r; cfg_edo = e; cfg_cbr = c;
      cfg_stagger = s; cfg_ref_period = p;
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int n, cnt, pdbad, c;
      string rq;
      rst_n = 1'b0;
      suspend_req = 1'b0;
      set_cfg(2'b00, 1'b0, 1'b0, 1'b0, 4'd1, 8'd4);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "rows in reset", int'(cke_row), 63);
      chk("R1", "glb in reset", int'(cke_glb), 1);
      chk("R1", "done in reset", int'(done), 0);
      chk("R1", "ref/sref in reset", int'({ref_req, sref_cmd}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "rows after reset", int'({cke_row, cke_glb}), 127);

      // table walk
      for (int v = 0; v < NV; v++) begin
         rq = $sformatf("R%0d", VT[v].req);
         set_cfg(VT[v].layout, VT[v].regd, VT[v].edo, VT[v].cbr, VT[v].stg, VT[v].per);
         suspend_req = 1'b0;
         repeat (3) @(negedge clk);
         chk("R5", $sformatf("pd_allow idle vec %0d", v), int'(pd_allow), int'(VT[v].pd));
         suspend_req = 1'b1;
         n = 0;
         do begin @(negedge clk); n++; end while (!done && n < 200);
         chk(rq, $sformatf("entry latency vec %0d", v), n, int'(VT[v].lat));
         chk(rq, $sformatf("rows in suspend vec %0d", v), int'(cke_row), int'(VT[v].rows));
         chk(rq, $sformatf("glb in suspend vec %0d", v), int'(cke_glb), int'(VT[v].glb));
         cnt = 0; pdbad = 0;
         for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (ref_req) cnt++;
            if (pd_allow) pdbad = 1;
         end
         chk(rq, $sformatf("refresh pulses vec %0d", v), cnt, int'(VT[v].nref));
         chk(rq, $sformatf("sref_cmd vec %0d", v), int'(sref_cmd), int'(VT[v].sref));
         chk("R5", $sformatf("pd in suspend vec %0d", v), pdbad, 0);
         suspend_req = 1'b0;
         n = 0;
         do begin @(negedge clk); n++; end
            while (!(!done && &cke_row && cke_glb) && n < 200);
         chk("R6", $sformatf("wake latency vec %0d", v), n, int'(VT[v].wlat));
         chk("R8", $sformatf("sref after wake vec %0d", v), int'(sref_cmd), 0);
      end

      // R2/R10 ordered entry with interval 2, then R9, then R6 ordered exit
      set_cfg(2'b00, 1'b0, 1'b0, 1'b0, 4'd2, 8'd4);
      repeat (3) @(negedge clk);
      suspend_req = 1'b1;
      for (int j = 0; j < 13; j++) begin
         @(negedge clk);
         c = (j / 2 > 6) ? 6 : j / 2;
         chk("R2", $sformatf("entry order step %0d", j), int'(cke_row), 63 & ~((1 << c) - 1));
         chk("R10", $sformatf("done step %0d", j), int'(done), (j >= 12) ? 1 : 0);
      end
      set_cfg(2'b01, 1'b1, 1'b1, 1'b1, 4'd1, 8'd1);
      cnt = 0; pdbad = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (ref_req) cnt++;
         if (cke_row != 6'h00 || sref_cmd) pdbad = 1;
      end
      chk("R9", "refresh after config change", cnt, 0);
      chk("R9", "rows/sref after config change", pdbad, 0);
      suspend_req = 1'b0;
      for (int j = 0; j < 13; j++) begin
         @(negedge clk);
         c = (j / 2 > 6) ? 6 : j / 2;
         chk("R6", $sformatf("exit order step %0d", j), int'(cke_row), (1 << c) - 1);
         if (j == 0) chk("R6", "done clears at wake", int'(done), 0);
      end

      // R6 collision: wake sampled on the edge that would lower row 5
      set_cfg(2'b00, 1'b0, 1'b0, 1'b0, 4'd1, 8'd4);
      repeat (3) @(negedge clk);
      suspend_req = 1'b1;
      repeat (6) @(negedge clk);
      suspend_req = 1'b0;
      @(negedge clk);
      chk("R6", "collision rows", int'(cke_row), 32);
      pdbad = int'(done);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (done) pdbad = 1;
      end
      chk("R6", "collision done never set", pdbad, 0);
      chk("R6", "collision rows restored", int'(cke_row), 63);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule